// File: doc/BRIEF.md
# Smart card T=0 character transceiver

This block sends and receives single characters on the one shared data line of a smart card that uses the T=0 protocol. The line is open-drain. The block can only pull the line low or release it, and an external pull-up sets the idle level. One input selects the direction of the block: transmit or receive. All bit timing comes from a programmable count of clock cycles per elementary time unit (etu).

A character takes ten etus on the line: a low start bit, the eight data bits least significant bit first, and an even parity bit. After these ten etus comes a window in which the receiving side may pull the line low to reject the character.

- **Receive mode.** The block checks parity. If parity is bad, the block sets a sticky parity-error flag and pulls the line low in the reject window. If parity is good, it stores the byte and sets a receive-full flag.
- **Transmit mode.** The block looks for a reject from the card. If it sees one, it sets an error-signal flag, waits a guard time and sends the same byte again, up to a programmable number of resends. The transmit-end flag is set only when a copy of the byte is accepted without a reject.
- **Interrupts.** The error and transmit-end flags each drive an interrupt request that has its own enable.

Top module: `sc_t0_xcvr`

## Requirements
- R1: In transmit mode, a `txStart` pulse sampled at clock edge E0 starts a frame. From the cycle after E0, the line carries ten bits of `etuDiv` cycles each: a low start bit, then data bits D0 to D7 (least significant first), then a parity bit. The parity bit makes the count of ones across the data bits and parity even.
- R2: The block never drives the line high. `ioDriveLow` is 0 whenever `busy` is 0, and it is 0 after reset.
- R3: In receive mode, a frame with correct parity loads `rxData` and sets `rxFull`. The block does not pull the line low in the reject window.
- R4: In receive mode, a frame with wrong parity sets `parErr` and leaves `rxData` unchanged. The block pulls the line low for one etu, starting half an etu after the parity bit ends.
- R5: In transmit mode, a low line at the sampling point one etu after the parity bit ends sets `errSig`. `errIrq` is high while `errSig` and `errIrqEn` are both high.
- R6: After a reject, the same byte is sent again. The new start bit begins 13 etus after the start of the rejected frame. `txEnd` stays low while the retry is in progress.
- R7: When no reject is seen, `txEnd` is set and `busy` falls at edge E0 + 13 × `etuDiv` × (number of frames sent). `endIrq` is high while `txEnd` and `endIrqEn` are both high.
- R8: If the character is still rejected after `retryMax` resends, the block stops sending and returns to idle. In that case `txEnd` stays low and `errSig` stays set.
- R9: `rxFull`, `parErr`, `errSig` and `txEnd` stay set until their own clear input is pulsed. All four are 0 after reset.
- R10: `txStart` is ignored in receive mode and while a transmission is in progress. It does not change the byte being sent.
- R11: In receive mode, a low pulse shorter than half an etu is treated as noise. The block returns to idle without setting any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| etuDiv | input | DIV_W | Clock cycles per etu, at least 4 |
| retryMax | input | RETRY_W | Maximum number of automatic resends of one character |
| modeTx | input | 1 | 1 selects transmit, 0 selects receive |
| txData | input | 8 | Byte to send, captured on an accepted `txStart` |
| txStart | input | 1 | One-cycle request to send `txData` |
| rxData | output | 8 | Last byte received with correct parity |
| rxFull | output | 1 | Sticky flag: a good byte was received |
| rxFullClr | input | 1 | Clears `rxFull` |
| parErr | output | 1 | Sticky flag: a received frame had a parity error |
| parErrClr | input | 1 | Clears `parErr` |
| errSig | output | 1 | Sticky flag: the card rejected a sent frame |
| errSigClr | input | 1 | Clears `errSig` |
| txEnd | output | 1 | Sticky flag: the character was accepted |
| txEndClr | input | 1 | Clears `txEnd` |
| errIrqEn | input | 1 | Enables `errIrq` |
| endIrqEn | input | 1 | Enables `endIrq` |
| errIrq | output | 1 | Error interrupt request |
| endIrq | output | 1 | Transmit-end interrupt request |
| busy | output | 1 | A frame, reject window or guard time is in progress |
| ioIn | input | 1 | Level seen on the data line |
| ioDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Receive is tried with three inputs:
- a byte with good parity, which separates accepting from rejecting;
- the same byte with its parity bit flipped, which must produce the reject pulse and leave the stored byte unchanged;
- a short noise pulse, which must not look like a start bit.

Transmit is tried with four cases, chosen so the frame count and timing differ:
- a clean byte;
- a byte rejected once, which shows the resend of the stored byte and the 13-etu spacing;
- a byte rejected more often than the retry limit allows, which must end without `txEnd`;
- a byte during whose frame a second start request with other data arrives.

The data patterns (alternating bits, all zeros, single set bits at both ends) catch bit-order and parity mistakes.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

  localparam int CHAR_W = 8;
  localparam int SLOT_W = 4;

  // Slot numbers within one character period, one etu each
  localparam logic [SLOT_W-1:0] SLOT_START     = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_PARITY    = 4'd9;
  localparam logic [SLOT_W-1:0] SLOT_ERR       = 4'd10;
  localparam logic [SLOT_W-1:0] SLOT_NACK_END  = 4'd11;
  localparam logic [SLOT_W-1:0] SLOT_GUARD_END = 4'd12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } scStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadTx;     // capture a new byte to send
    logic              frameStart; // a frame (first or resend) begins
    logic              txDrive;    // transmitter owns the line this cycle
    logic [SLOT_W-1:0] slot;       // current etu slot
    logic              capture;    // mid-etu sample of a received bit
    logic              rxFinish;   // received frame complete, judge parity
    logic              nackWin;    // reject window of the receiver
    logic              errSample;  // transmitter samples for a reject
    logic              txFinish;   // character accepted
  } scStrobeT;

endpackage

// File: rtl/sc_t0_ctrl.sv
module sc_t0_ctrl
  import sc_t0_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   etuDiv,
  input  logic [RETRY_W-1:0] retryMax,
  input  logic               modeTx,
  input  logic               txStart,
  input  logic               lineLow,
  input  logic               errFrame,
  output scStrobeT           strb,
  output logic               busy
);

  scStateT            state;
  logic [DIV_W-1:0]   etuCnt;
  logic [SLOT_W-1:0]  slot;
  logic [RETRY_W-1:0] retryCnt;

  logic [DIV_W-1:0] halfEtu;
  logic             etuEnd, etuMid, retryGo, txReq, rxReq;

  assign halfEtu = etuDiv >> 1;
  assign etuEnd  = (etuCnt == etuDiv - DIV_W'(1));
  assign etuMid  = (etuCnt == halfEtu);
  assign retryGo = errFrame && (retryCnt < retryMax);
  assign txReq   = modeTx && txStart;
  assign rxReq   = !modeTx && lineLow;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strb      = '0;
    strb.slot = slot;
    unique case (state)
      ST_IDLE: begin
        strb.loadTx     = txReq;
        strb.frameStart = txReq || rxReq;
      end
      ST_TX: begin
        strb.txDrive   = (slot <= SLOT_PARITY);
        strb.errSample = etuEnd && (slot == SLOT_ERR);
        if (etuEnd && (slot == SLOT_GUARD_END)) begin
          strb.frameStart = retryGo;
          strb.txFinish   = !errFrame;
        end
      end
      ST_RX: begin
        strb.capture  = etuMid && (slot != SLOT_START) && (slot <= SLOT_PARITY);
        strb.rxFinish = etuEnd && (slot == SLOT_PARITY);
        strb.nackWin  = ((slot == SLOT_ERR) && (etuCnt >= halfEtu)) ||
                        ((slot == SLOT_NACK_END) && (etuCnt < halfEtu));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      etuCnt   <= '0;
      slot     <= '0;
      retryCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          etuCnt   <= '0;
          slot     <= '0;
          retryCnt <= '0;
          if (txReq)      state <= ST_TX;
          else if (rxReq) state <= ST_RX;
        end
        ST_TX: begin
          if (etuEnd) begin
            etuCnt <= '0;
            if (slot == SLOT_GUARD_END) begin
              slot <= '0;
              if (retryGo) retryCnt <= retryCnt + RETRY_W'(1);
              else         state    <= ST_IDLE;
            end else begin
              slot <= slot + SLOT_W'(1);
            end
          end else begin
            etuCnt <= etuCnt + DIV_W'(1);
          end
        end
        ST_RX: begin
          if ((slot == SLOT_START) && etuMid && !lineLow) begin
            state <= ST_IDLE;
          end else if (etuEnd) begin
            etuCnt <= '0;
            if (slot == SLOT_NACK_END) state <= ST_IDLE;
            else                       slot  <= slot + SLOT_W'(1);
          end else begin
            etuCnt <= etuCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_t0_datapath.sv
module sc_t0_datapath
  import sc_t0_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  scStrobeT          strb,
  input  logic [CHAR_W-1:0] txData,
  input  logic              ioIn,
  input  logic              rxFullClr,
  input  logic              parErrClr,
  input  logic              errSigClr,
  input  logic              txEndClr,
  input  logic              errIrqEn,
  input  logic              endIrqEn,
  output logic              lineLow,
  output logic              errFrame,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxFull,
  output logic              parErr,
  output logic              errSig,
  output logic              txEnd,
  output logic              errIrq,
  output logic              endIrq,
  output logic              ioDriveLow
);

  localparam int SEL_W = $clog2(CHAR_W);

  logic [1:0]        syncQ;
  logic [CHAR_W-1:0] txByte, rxShift;
  logic              rxPar, nackPend, txBit, rxBad;
  logic [SEL_W-1:0]  bitSel;

  assign lineLow = syncQ[1];
  assign bitSel  = SEL_W'(strb.slot - SLOT_W'(1));
  assign rxBad   = ^{rxShift, rxPar};

  always_comb begin
    if (strb.slot == SLOT_START)       txBit = 1'b0;
    else if (strb.slot == SLOT_PARITY) txBit = ^txByte;
    else                               txBit = txByte[bitSel];
  end

  // Open drain: only ever pull low or release
  assign ioDriveLow = (strb.txDrive && !txBit) || (strb.nackWin && nackPend);
  assign errIrq     = errSig && errIrqEn;
  assign endIrq     = txEnd && endIrqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      txByte   <= '0;
      rxShift  <= '0;
      rxPar    <= 1'b0;
      rxData   <= '0;
      nackPend <= 1'b0;
      errFrame <= 1'b0;
      rxFull   <= 1'b0;
      parErr   <= 1'b0;
      errSig   <= 1'b0;
      txEnd    <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], !ioIn};

      if (strb.loadTx) txByte <= txData;

      if (strb.capture) begin
        if (strb.slot == SLOT_PARITY) rxPar   <= !lineLow;
        else                          rxShift <= {!lineLow, rxShift[CHAR_W-1:1]};
      end

      if (strb.frameStart)     nackPend <= 1'b0;
      else if (strb.rxFinish)  nackPend <= rxBad;

      if (strb.frameStart)     errFrame <= 1'b0;
      else if (strb.errSample) errFrame <= lineLow;

      if (strb.rxFinish && !rxBad) rxData <= rxShift;

      if (strb.rxFinish && !rxBad) rxFull <= 1'b1;
      else if (rxFullClr)          rxFull <= 1'b0;

      if (strb.rxFinish && rxBad)  parErr <= 1'b1;
      else if (parErrClr)          parErr <= 1'b0;

      if (strb.errSample && lineLow) errSig <= 1'b1;
      else if (errSigClr)            errSig <= 1'b0;

      if (strb.txFinish)   txEnd <= 1'b1;
      else if (txEndClr)   txEnd <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_t0_xcvr.sv
module sc_t0_xcvr
  import sc_t0_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   etuDiv,
  input  logic [RETRY_W-1:0] retryMax,
  input  logic               modeTx,
  input  logic [7:0]         txData,
  input  logic               txStart,
  output logic [7:0]         rxData,
  output logic               rxFull,
  input  logic               rxFullClr,
  output logic               parErr,
  input  logic               parErrClr,
  output logic               errSig,
  input  logic               errSigClr,
  output logic               txEnd,
  input  logic               txEndClr,
  input  logic               errIrqEn,
  input  logic               endIrqEn,
  output logic               errIrq,
  output logic               endIrq,
  output logic               busy,
  input  logic               ioIn,
  output logic               ioDriveLow
);

  scStrobeT strb;
  logic     lineLow, errFrame;

  sc_t0_ctrl #(.DIV_W(DIV_W), .RETRY_W(RETRY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .etuDiv(etuDiv), .retryMax(retryMax),
    .modeTx(modeTx), .txStart(txStart), .lineLow(lineLow),
    .errFrame(errFrame), .strb(strb), .busy(busy)
  );

  sc_t0_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .ioIn(ioIn),
    .rxFullClr(rxFullClr), .parErrClr(parErrClr), .errSigClr(errSigClr),
    .txEndClr(txEndClr), .errIrqEn(errIrqEn), .endIrqEn(endIrqEn),
    .lineLow(lineLow), .errFrame(errFrame), .rxData(rxData),
    .rxFull(rxFull), .parErr(parErr), .errSig(errSig), .txEnd(txEnd),
    .errIrq(errIrq), .endIrq(endIrq), .ioDriveLow(ioDriveLow)
  );

endmodule

// File: rtl/sc_t0_checker.sv
module sc_t0_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic modeTx,
  input logic ioDriveLow,
  input logic txEnd,
  input logic rxFull,
  input logic errSig
);

  assert_no_idle_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ioDriveLow);

  assert_end_at_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> (!busy && modeTx));

  assert_full_in_rx_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> (busy && !modeTx));

  assert_err_in_tx_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSig) |-> (busy && modeTx));

endmodule

bind sc_t0_xcvr sc_t0_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .modeTx(modeTx),
  .ioDriveLow(ioDriveLow), .txEnd(txEnd), .rxFull(rxFull), .errSig(errSig)
);

// File: tb/sim_sc_t0_xcvr.sv
module sim_sc_t0_xcvr;

  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic [11:0] etuDiv;
  logic [2:0] retryMax;
  logic       modeTx, txStart, rxFullClr, parErrClr, errSigClr, txEndClr;
  logic       errIrqEn, endIrqEn, cardLow, ioIn;
  logic [7:0] txData, rxData;
  logic       rxFull, parErr, errSig, txEnd, errIrq, endIrq, busy, ioDriveLow;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  int nackLeft = 0;
  logic [9:0] monBits;
  logic [7:0] monExp;

  always #4 clk = ~clk;

  assign ioIn = ~(ioDriveLow | cardLow);

  sc_t0_xcvr u0 (
    .clk(clk), .rstN(rstN), .etuDiv(etuDiv), .retryMax(retryMax),
    .modeTx(modeTx), .txData(txData), .txStart(txStart), .rxData(rxData),
    .rxFull(rxFull), .rxFullClr(rxFullClr), .parErr(parErr),
    .parErrClr(parErrClr), .errSig(errSig), .errSigClr(errSigClr),
    .txEnd(txEnd), .txEndClr(txEndClr), .errIrqEn(errIrqEn),
    .endIrqEn(endIrqEn), .errIrq(errIrq), .endIrq(endIrq), .busy(busy),
    .ioIn(ioIn), .ioDriveLow(ioDriveLow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: card model that decodes transmitted frames and may reject them
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && modeTx && ioDriveLow) begin
        repeat (D/2) @(negedge clk);
        monBits[0] = ~ioDriveLow;
        for (int k = 1; k < 10; k++) begin
          repeat (D) @(negedge clk);
          monBits[k] = ~ioDriveLow;
        end
        check(monBits[0] == 1'b0, "R1 start bit low", monBits[0], 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected frame", monBits[8:1], 0);
        end else begin
          monExp = expQ.pop_front();
          check(monBits[8:1] == monExp, "R1 data bits", monBits[8:1], monExp);
        end
        check(monBits[9] == ^monBits[8:1], "R1 even parity", monBits[9], ^monBits[8:1]);
        if (nackLeft > 0) begin
          repeat (D) @(negedge clk);
          cardLow = 1'b1;
          repeat (D) @(negedge clk);
          cardLow = 1'b0;
          nackLeft--;
        end
        while (ioDriveLow) @(negedge clk);
      end
    end
  end

  // Driver: send one character, pushing expected frames to the scoreboard
  task automatic sendTx(input logic [7:0] b, input int nacks, input bit inject);
    int frames;
    int cnt;
    frames = (nacks <= int'(retryMax)) ? nacks + 1 : int'(retryMax) + 1;
    nackLeft = (nacks < frames) ? nacks : frames;
    for (int i = 0; i < frames; i++) expQ.push_back(b);
    @(negedge clk);
    txData  = b;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    cnt = 1;
    while (busy && cnt < 20*13*D) begin
      if (cnt == 14*D && nacks > 0) begin
        check(txEnd == 1'b0, "R6 txEnd held during retry", txEnd, 0);
        check(errSig == 1'b1, "R5 errSig after reject", errSig, 1);
        check(errIrq == errIrqEn, "R5 errIrq", errIrq, errIrqEn);
      end
      if (inject && cnt == 3*D) begin
        txData  = ~b;
        txStart = 1'b1;
      end
      @(negedge clk);
      txStart = 1'b0;
      cnt++;
    end
    check(cnt == 13*D*frames + 1, "R7 R6 busy duration", cnt, 13*D*frames + 1);
    check(expQ.size() == 0, "R1 frames sent", expQ.size(), 0);
  endtask

  // Card sends one frame to the block
  task automatic rxFrame(input logic [7:0] b, input bit bad);
    logic [9:0] fr;
    fr = {(^b) ^ bad, b, 1'b0};
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      cardLow = ~fr[k];
      repeat (D) @(negedge clk);
    end
    cardLow = 1'b0;
    repeat (D) @(negedge clk);
    check(ioDriveLow == bad, bad ? "R4 reject pulse" : "R3 line released", ioDriveLow, bad);
    repeat (D) @(negedge clk);
    check(ioDriveLow == 1'b0, "R4 reject lasts one etu", ioDriveLow, 0);
    while (busy) @(negedge clk);
    repeat (2*D) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    bit seen;
    rstN = 1'b0; etuDiv = 12'(D); retryMax = 3'd2; modeTx = 1'b0;
    txData = 8'h00; txStart = 1'b0; rxFullClr = 1'b0; parErrClr = 1'b0;
    errSigClr = 1'b0; txEndClr = 1'b0; errIrqEn = 1'b0; endIrqEn = 1'b0;
    cardLow = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // Reset state (R2, R9)
    check(busy == 0 && ioDriveLow == 0, "R2 reset idle", {busy, ioDriveLow}, 0);
    check({rxFull, parErr, errSig, txEnd, errIrq, endIrq} == 6'b0, "R9 reset flags",
          {rxFull, parErr, errSig, txEnd, errIrq, endIrq}, 0);

    // R3: good frame
    rxFrame(8'hA5, 1'b0);
    check(rxFull == 1'b1, "R3 rxFull set", rxFull, 1);
    check(rxData == 8'hA5, "R3 rxData", rxData, 8'hA5);
    check(parErr == 1'b0, "R3 no parity error", parErr, 0);

    // R4: bad parity
    rxFrame(8'h3C, 1'b1);
    check(parErr == 1'b1, "R4 parErr set", parErr, 1);
    check(rxData == 8'hA5, "R4 rxData unchanged", rxData, 8'hA5);

    // Resend received cleanly; flags sticky (R9)
    rxFrame(8'h3C, 1'b0);
    check(rxData == 8'h3C, "R3 rxData after resend", rxData, 8'h3C);
    check(parErr == 1'b1 && rxFull == 1'b1, "R9 flags sticky", {parErr, rxFull}, 3);
    @(negedge clk); rxFullClr = 1'b1; parErrClr = 1'b1;
    @(negedge clk); rxFullClr = 1'b0; parErrClr = 1'b0;
    check(rxFull == 1'b0 && parErr == 1'b0, "R9 flags cleared", {rxFull, parErr}, 0);

    // R11: short noise pulse
    @(negedge clk); cardLow = 1'b1;
    repeat (3) @(negedge clk); cardLow = 1'b0;
    repeat (D) @(negedge clk);
    check(busy == 1'b0, "R11 noise rejected", busy, 0);
    check(rxFull == 0 && parErr == 0, "R11 no flags", {rxFull, parErr}, 0);

    // R10: txStart in receive mode
    @(negedge clk); txData = 8'h77; txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    seen = 1'b0;
    repeat (2*D) begin
      @(negedge clk);
      if (ioDriveLow || busy) seen = 1'b1;
    end
    check(seen == 1'b0, "R10 txStart ignored in receive", seen, 0);

    // Transmit mode
    modeTx = 1'b1; errIrqEn = 1'b1; endIrqEn = 1'b1;
    repeat (D) @(negedge clk);

    // R7: clean send
    sendTx(8'h5A, 0, 1'b0);
    check(txEnd == 1'b1, "R7 txEnd set", txEnd, 1);
    check(endIrq == 1'b1, "R7 endIrq", endIrq, 1);
    check(errSig == 1'b0, "R5 no errSig on clean frame", errSig, 0);
    @(negedge clk); txEndClr = 1'b1;
    @(negedge clk); txEndClr = 1'b0;
    check(txEnd == 1'b0, "R9 txEnd cleared", txEnd, 0);

    // R5, R6: one reject then accept
    sendTx(8'hC3, 1, 1'b0);
    check(txEnd == 1'b1, "R6 txEnd after resend", txEnd, 1);
    check(errSig == 1'b1, "R9 errSig sticky", errSig, 1);
    @(negedge clk); txEndClr = 1'b1; errSigClr = 1'b1;
    @(negedge clk); txEndClr = 1'b0; errSigClr = 1'b0;
    check(errSig == 1'b0 && errIrq == 1'b0, "R9 errSig cleared", {errSig, errIrq}, 0);

    // R8: rejected beyond retry limit
    sendTx(8'h81, 3, 1'b0);
    check(txEnd == 1'b0, "R8 no txEnd on give-up", txEnd, 0);
    check(errSig == 1'b1, "R8 errSig kept", errSig, 1);
    @(negedge clk); errSigClr = 1'b1;
    @(negedge clk); errSigClr = 1'b0;

    // R10: second start while busy; interrupt enables off
    errIrqEn = 1'b0; endIrqEn = 1'b0;
    sendTx(8'h00, 0, 1'b1);
    check(txEnd == 1'b1 && endIrq == 1'b0, "R7 endIrq masked", {txEnd, endIrq}, 2);
    repeat (2*D) @(negedge clk);
    check(busy == 1'b0 && expQ.size() == 0, "R10 no extra frame", busy, 0);

    finishRun();
  end

endmodule